// File: doc/BRIEF.md
# Outstanding Request Tag Table

This block tracks every transaction still in flight on a split-transaction bus whose responses may return out of order. When a request wins the address bus, the bus gives it a small tag. Every cache controller writes that request into its own copy of the table at the index the tag names. The entry holds the block address, whether the request is a shared read or an exclusive read, and this cache's snoop verdict once that is known. The entry is released when a response carrying the same tag shows up on the data bus, so the bus can hand the tag out again.

The table is indexed by tag, but it is searched by address across all entries at once. The processor side uses the search before it issues a miss. A read that meets a pending read for the same block joins it: a grab bit is set so the data is captured when the response passes. Any other overlap stalls the issue and the processor retries later. The bus side uses the same search to flag an incoming request that overlaps a pending one. Snoop verdicts found during the request phase are parked in the entry and handed back when the response arrives. A cache that joins a read it did not start also raises the shared indication, so that other caches install the block as shared rather than exclusive. Write-backs and upgrades never receive a response, so they never occupy an entry.

Top module: `req_tag_table`

## Requirements
- R1: After reset every entry is free: `full_o` is low, a processor lookup on any address gives `cpu_issue_o`=1, `cpu_retry_o`=0 and `cpu_join_o`=0, and a response on any tag gives `resp_hit_o`=0.
- R2: A bus allocation of request class 0 (shared read) or 1 (exclusive read) writes the entry at `alloc_tag_i`, effective from the next cycle. Lookups then match it by address, whatever its tag.
- R3: Allocations of class 2 (upgrade) or class 3 (write-back) create no entry. A later processor lookup on their address still gives `cpu_issue_o`=1.
- R4: A processor exclusive read (class 1) that matches any pending entry, or a shared read (class 0) that matches a pending exclusive read, gives `cpu_retry_o`=1 and `cpu_issue_o`=0.
- R5: A processor shared read that matches a pending shared read gives `cpu_join_o`=1 and `cpu_join_tag_o` equal to that entry's tag. In that cycle the entry's grab bit is set. The response for that tag then drives `resp_grab_o`=1.
- R6: A snoop verdict on `snoop_res_i` (bit 2 shared, bit 1 dirty, bit 0 inhibit) for a pending tag is stored and appears on `resp_res_o` when that tag's response arrives. A verdict for a free tag is dropped. A freshly written entry starts with an all-zero verdict.
- R7: A response on `resp_tag_i` for a pending entry gives `resp_hit_o`=1 with `resp_orig_o` showing whether this cache issued it, and frees the entry from the next cycle on.
- R8: `full_o` is high exactly when all entries are pending. While it is high, `cpu_issue_o` stays low.
- R9: When an allocation and a response name the same tag in one cycle, the release is applied first, so the new request is the one left pending.
- R10: `bus_hit_o` is high when an allocation's address matches a pending entry.
- R11: The shared bit of `resp_res_o` is also set when the grab bit is set and the entry was not issued by this cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| alloc_valid_i | input | 1 | A request was granted the address bus |
| alloc_tag_i | input | TAG_W | Tag given to that request |
| alloc_addr_i | input | ADDR_W | Block address of the request |
| alloc_kind_i | input | 2 | Request class: 0 shared read, 1 exclusive read, 2 upgrade, 3 write-back |
| alloc_own_i | input | 1 | The request was issued by this cache |
| snoop_valid_i | input | 1 | Local snoop verdict is ready |
| snoop_tag_i | input | TAG_W | Tag the verdict belongs to |
| snoop_res_i | input | 3 | Verdict: shared, dirty, inhibit |
| resp_valid_i | input | 1 | A response is on the data bus |
| resp_tag_i | input | TAG_W | Tag carried by the response |
| cpu_valid_i | input | 1 | Processor miss lookup |
| cpu_addr_i | input | ADDR_W | Block address of the miss |
| cpu_kind_i | input | 2 | Class of the miss (0 or 1) |
| full_o | output | 1 | Every tag is in use |
| bus_hit_o | output | 1 | Allocation overlaps a pending entry |
| cpu_issue_o | output | 1 | Miss may be sent to the bus |
| cpu_retry_o | output | 1 | Miss conflicts and must wait |
| cpu_join_o | output | 1 | Miss joins a pending shared read |
| cpu_join_tag_o | output | TAG_W | Tag of the joined entry |
| resp_hit_o | output | 1 | Response tag names a pending entry |
| resp_res_o | output | 3 | Verdict to drive with the response |
| resp_grab_o | output | 1 | This cache must capture the response data |
| resp_orig_o | output | 1 | This cache issued the request |

## Verification
The hardest case to reach is a free and a fresh write landing on the same tag in one cycle while every other tag is busy. The bench fills all eight tags one per cycle, then applies a response and a new allocation to one tag together. It confirms through a processor lookup that the new address joins at that tag and the old address is gone, while `full_o` stays high. The grab-driven shared indication is reached the same way. A processor read joins a pending read issued elsewhere, a dirty verdict is parked, and the response must return both bits merged.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef enum logic [1:0] {
    RK_READ  = 2'd0,
    RK_READX = 2'd1,
    RK_UPGR  = 2'd2,
    RK_WB    = 2'd3
  } req_kind_e;

  localparam int unsigned SNP_W = 3;
  localparam int unsigned SNP_SHARED = 2;
  localparam int unsigned SNP_DIRTY  = 1;
  localparam int unsigned SNP_INHIB  = 0;
endpackage

// File: rtl/rtt_slot.sv
module rtt_slot
  import rtt_pkg::*;
#(
  parameter int unsigned ADDR_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_read_i,
  input  logic              wr_own_i,
  input  logic              free_i,
  input  logic              snp_we_i,
  input  logic [SNP_W-1:0]  snp_i,
  input  logic              grab_set_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              valid_o,
  output logic              read_o,
  output logic              own_o,
  output logic              grab_o,
  output logic [SNP_W-1:0]  snp_o,
  output logic              cpu_hit_o,
  output logic              bus_hit_o
);
  logic [ADDR_W-1:0] addr_q;

  // write wins over free: release is applied first, then the new entry
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      read_o  <= 1'b0;
      own_o   <= 1'b0;
      grab_o  <= 1'b0;
      snp_o   <= '0;
      addr_q  <= '0;
    end else if (wr_i) begin
      valid_o <= 1'b1;
      read_o  <= wr_read_i;
      own_o   <= wr_own_i;
      grab_o  <= 1'b0;
      snp_o   <= '0;
      addr_q  <= wr_addr_i;
    end else if (free_i) begin
      valid_o <= 1'b0;
      grab_o  <= 1'b0;
      snp_o   <= '0;
    end else if (valid_o) begin
      if (snp_we_i)   snp_o  <= snp_i;
      if (grab_set_i) grab_o <= 1'b1;
    end
  end

  assign cpu_hit_o = valid_o && (addr_q == cpu_addr_i);
  assign bus_hit_o = valid_o && (addr_q == bus_addr_i);
endmodule

// File: rtl/rtt_lookup.sv
module rtt_lookup #(
  parameter int unsigned N     = 8,
  parameter int unsigned TAG_W = $clog2(N)
) (
  input  logic [N-1:0]     hit_i,
  input  logic [N-1:0]     read_i,
  input  logic             cpu_read_i,
  output logic             any_o,
  output logic             conflict_o,
  output logic             join_o,
  output logic [TAG_W-1:0] join_tag_o
);
  logic [N-1:0] joinable;

  assign joinable   = hit_i & read_i & {N{cpu_read_i}};
  assign any_o      = |hit_i;
  assign conflict_o = |(hit_i & ~joinable);
  assign join_o     = (|joinable) && !conflict_o;

  always_comb begin
    join_tag_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (joinable[i]) join_tag_o = TAG_W'(i);
    end
  end
endmodule

// File: rtl/req_tag_table.sv
module req_tag_table
  import rtt_pkg::*;
#(
  parameter int unsigned TAG_W  = 3,
  parameter int unsigned ADDR_W = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [TAG_W-1:0]  alloc_tag_i,
  input  logic [ADDR_W-1:0] alloc_addr_i,
  input  logic [1:0]        alloc_kind_i,
  input  logic              alloc_own_i,
  input  logic              snoop_valid_i,
  input  logic [TAG_W-1:0]  snoop_tag_i,
  input  logic [2:0]        snoop_res_i,
  input  logic              resp_valid_i,
  input  logic [TAG_W-1:0]  resp_tag_i,
  input  logic              cpu_valid_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [1:0]        cpu_kind_i,
  output logic              full_o,
  output logic              bus_hit_o,
  output logic              cpu_issue_o,
  output logic              cpu_retry_o,
  output logic              cpu_join_o,
  output logic [TAG_W-1:0]  cpu_join_tag_o,
  output logic              resp_hit_o,
  output logic [2:0]        resp_res_o,
  output logic              resp_grab_o,
  output logic              resp_orig_o
);
  localparam int unsigned N = 1 << TAG_W;

  logic [N-1:0]     valid_q, read_q, own_q, grab_q, cpu_hit, bus_hit;
  logic [SNP_W-1:0] snp_q [N];
  logic             alloc_store, cpu_read, any_hit, conflict, join_hit;
  logic [TAG_W-1:0] join_tag;

  // upgrades and write-backs get no response, so never occupy a slot
  assign alloc_store = alloc_valid_i &&
                       (alloc_kind_i == RK_READ || alloc_kind_i == RK_READX);
  assign cpu_read    = (cpu_kind_i == RK_READ);

  for (genvar i = 0; i < N; i++) begin : g_slot
    rtt_slot #(.ADDR_W(ADDR_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_i       (alloc_store && alloc_tag_i == TAG_W'(i)),
      .wr_addr_i  (alloc_addr_i),
      .wr_read_i  (alloc_kind_i == RK_READ),
      .wr_own_i   (alloc_own_i),
      .free_i     (resp_valid_i && resp_tag_i == TAG_W'(i)),
      .snp_we_i   (snoop_valid_i && snoop_tag_i == TAG_W'(i)),
      .snp_i      (snoop_res_i),
      .grab_set_i (cpu_valid_i && join_hit && join_tag == TAG_W'(i)),
      .cpu_addr_i (cpu_addr_i),
      .bus_addr_i (alloc_addr_i),
      .valid_o    (valid_q[i]),
      .read_o     (read_q[i]),
      .own_o      (own_q[i]),
      .grab_o     (grab_q[i]),
      .snp_o      (snp_q[i]),
      .cpu_hit_o  (cpu_hit[i]),
      .bus_hit_o  (bus_hit[i])
    );
  end

  rtt_lookup #(.N(N), .TAG_W(TAG_W)) u_lookup (
    .hit_i      (cpu_hit),
    .read_i     (read_q),
    .cpu_read_i (cpu_read),
    .any_o      (any_hit),
    .conflict_o (conflict),
    .join_o     (join_hit),
    .join_tag_o (join_tag)
  );

  assign full_o         = &valid_q;
  assign bus_hit_o      = alloc_valid_i && (|bus_hit);
  assign cpu_issue_o    = cpu_valid_i && !any_hit && !full_o;
  assign cpu_retry_o    = cpu_valid_i && conflict;
  assign cpu_join_o     = cpu_valid_i && join_hit;
  assign cpu_join_tag_o = join_tag;

  always_comb begin
    resp_hit_o  = resp_valid_i && valid_q[resp_tag_i];
    resp_grab_o = resp_hit_o && grab_q[resp_tag_i];
    resp_orig_o = resp_hit_o && own_q[resp_tag_i];
    resp_res_o  = resp_hit_o ? snp_q[resp_tag_i] : '0;
    // a joiner that did not start the read forces shared install elsewhere
    if (resp_grab_o && !own_q[resp_tag_i]) resp_res_o[SNP_SHARED] = 1'b1;
  end
endmodule

// File: rtl/rtt_chk.sv
module rtt_chk #(
  parameter int unsigned TAG_W = 3,
  parameter int unsigned N     = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             alloc_valid_i,
  input logic [TAG_W-1:0] alloc_tag_i,
  input logic [1:0]       alloc_kind_i,
  input logic             resp_valid_i,
  input logic [TAG_W-1:0] resp_tag_i,
  input logic [N-1:0]     valid_q,
  input logic             full_o,
  input logic             cpu_issue_o,
  input logic             cpu_retry_o,
  input logic             cpu_join_o
);
  logic stores, same_tag;
  assign stores   = alloc_valid_i && !alloc_kind_i[1];
  assign same_tag = alloc_valid_i && resp_valid_i && alloc_tag_i == resp_tag_i;

  // R2
  alloc_takes_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stores |=> valid_q[$past(alloc_tag_i)]);

  // R3
  no_slot_for_wb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_kind_i[1] && !valid_q[alloc_tag_i])
      |=> !valid_q[$past(alloc_tag_i)]);

  // R7
  resp_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_i && !same_tag) |=> !valid_q[$past(resp_tag_i)]);

  // R8
  full_blocks_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !cpu_issue_o);

  // R4
  retry_excludes_join_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_retry_o |-> !cpu_join_o && !cpu_issue_o);
endmodule

bind req_tag_table rtt_chk #(.TAG_W(TAG_W), .N(N)) u_rtt_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .alloc_valid_i (alloc_valid_i),
  .alloc_tag_i   (alloc_tag_i),
  .alloc_kind_i  (alloc_kind_i),
  .resp_valid_i  (resp_valid_i),
  .resp_tag_i    (resp_tag_i),
  .valid_q       (valid_q),
  .full_o        (full_o),
  .cpu_issue_o   (cpu_issue_o),
  .cpu_retry_o   (cpu_retry_o),
  .cpu_join_o    (cpu_join_o)
);

// File: tb/sim_req_tag_table.sv
`timescale 1ns/1ps
module sim_req_tag_table;
  localparam int TW = 3;
  localparam int AW = 26;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic alloc_valid_i, alloc_own_i, snoop_valid_i, resp_valid_i, cpu_valid_i;
  logic [TW-1:0] alloc_tag_i, snoop_tag_i, resp_tag_i;
  logic [AW-1:0] alloc_addr_i, cpu_addr_i;
  logic [1:0] alloc_kind_i, cpu_kind_i;
  logic [2:0] snoop_res_i;
  logic full_o, bus_hit_o, cpu_issue_o, cpu_retry_o, cpu_join_o;
  logic [TW-1:0] cpu_join_tag_o;
  logic resp_hit_o, resp_grab_o, resp_orig_o;
  logic [2:0] resp_res_o;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  req_tag_table #(.TAG_W(TW), .ADDR_W(AW)) u0 (.*);

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    alloc_valid_i = 0; alloc_tag_i = 0; alloc_addr_i = 0; alloc_kind_i = 0;
    alloc_own_i = 0; snoop_valid_i = 0; snoop_tag_i = 0; snoop_res_i = 0;
    resp_valid_i = 0; resp_tag_i = 0; cpu_valid_i = 0; cpu_addr_i = 0;
    cpu_kind_i = 0;
  endtask

  // drive after negedge, sample 1 ns later, before the next posedge
  task automatic next();
    @(negedge clk_i);
    idle();
  endtask

  task automatic alloc(input int tag, input int addr, input int kind, input bit own);
    next();
    alloc_valid_i = 1; alloc_tag_i = TW'(tag); alloc_addr_i = AW'(addr);
    alloc_kind_i = 2'(kind); alloc_own_i = own;
  endtask

  task automatic look(input int addr, input int kind);
    next();
    cpu_valid_i = 1; cpu_addr_i = AW'(addr); cpu_kind_i = 2'(kind);
    #1;
  endtask

  task automatic resp(input int tag);
    next();
    resp_valid_i = 1; resp_tag_i = TW'(tag);
    #1;
  endtask

  task automatic t_reset();
    look('h55, 0);
    chk(full_o, 0, "R1 full");
    chk(cpu_issue_o, 1, "R1 issue");
    chk(cpu_retry_o + cpu_join_o, 0, "R1 retry/join");
    resp(3);
    chk(resp_hit_o, 0, "R1 resp_hit");
  endtask

  task automatic t_conflict();
    alloc(5, 'hA0, 1, 1);
    look('hA0, 0);
    chk(cpu_retry_o, 1, "R4 read vs readx retry");
    chk(cpu_issue_o, 0, "R4 issue blocked");
    look('hB0, 1);
    chk(cpu_issue_o, 1, "R2 unrelated addr issues");
    alloc(2, 'hA0, 3, 0);
    #1 chk(bus_hit_o, 1, "R10 bus overlap");
    alloc(3, 'hC0, 2, 0);
    #1 chk(bus_hit_o, 0, "R10 no overlap");
    look('hC0, 1);
    chk(cpu_issue_o, 1, "R3 upgrade not stored");
    look('hA0, 1);
    chk(cpu_retry_o, 1, "R4 readx vs pending");
    resp(5);
    chk(resp_hit_o, 1, "R7 resp hit");
    chk(resp_orig_o, 1, "R7 orig");
    look('hA0, 1);
    chk(cpu_issue_o, 1, "R7 slot freed");
  endtask

  task automatic t_join();
    alloc(1, 'hD0, 0, 0);
    look('hD0, 0);
    chk(cpu_join_o, 1, "R5 join");
    chk(cpu_join_tag_o, 1, "R5 join tag");
    chk(cpu_retry_o, 0, "R5 no retry");
    look('hD0, 1);
    chk(cpu_retry_o, 1, "R4 readx vs read");
    next();
    snoop_valid_i = 1; snoop_tag_i = 1; snoop_res_i = 3'b010;
    next();
    snoop_valid_i = 1; snoop_tag_i = 6; snoop_res_i = 3'b111;
    resp(1);
    chk(resp_hit_o, 1, "R7 hit");
    chk(resp_grab_o, 1, "R5 grab");
    chk(resp_orig_o, 0, "R7 not orig");
    chk(resp_res_o, 3'b110, "R6 R11 verdict");
    resp(6);
    chk(resp_hit_o, 0, "R6 free tag verdict dropped");
    chk(resp_res_o, 0, "R6 no verdict");
  endtask

  task automatic t_full();
    for (int i = 0; i < 8; i++) alloc(i, 'h100 + i, 0, 1);
    look('h300, 0);
    chk(full_o, 1, "R8 full");
    chk(cpu_issue_o, 0, "R8 issue blocked");
    next();
    resp_valid_i = 1; resp_tag_i = 4;
    alloc_valid_i = 1; alloc_tag_i = 4; alloc_addr_i = 'h200; alloc_kind_i = 0;
    alloc_own_i = 1;
    look('h200, 0);
    chk(full_o, 1, "R9 still full");
    chk(cpu_join_o, 1, "R9 new entry kept");
    chk(cpu_join_tag_o, 4, "R9 tag");
    look('h104, 0);
    chk(cpu_join_o, 0, "R9 old entry gone");
    resp(4);
    chk(resp_grab_o, 1, "R5 own grab");
    chk(resp_res_o, 0, "R11 own read no shared");
    chk(resp_res_o, 0, "R6 fresh entry zero verdict");
    look('h300, 0);
    chk(full_o, 0, "R8 not full");
    chk(cpu_issue_o, 1, "R8 issue resumes");
    for (int i = 0; i < 8; i++) resp(i);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_conflict();
    t_join();
    t_full();
    next();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule